// File: doc/BRIEF.md
# Dual-Tone Alert Qualifier and Mode Controller

This block is the digital controller that sits behind the analog stages of a caller-identity receiver. It decodes a two-bit operating selection into one of four modes: tone-alert, FSK receive, and two zero-power variants. It then routes the right detector onto a detect output (`det_o`) and an active-low interrupt (`irq_n_o`).

In tone-alert mode, the block times each burst of the dual-tone flag against a 1 ms tick. A burst raises the interrupt only when it ends with a duration inside a qualifying window. The raised interrupt stays latched until the selection moves away from tone-alert.

In FSK mode, the signal-level flag is filtered with a long on-delay and a shorter off-delay, so the detect output does not chatter. The 1 ms tick is divided down from the system clock. All timers and the latch restart whenever the decoded mode changes.

Top module: `tone_alert_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `det_o` is 0 and `irq_n_o` is 1.
- R2: The mode is decoded as follows: `sel_zp`=0 with `sel_mode`=0 is tone-alert; `sel_zp`=0 with `sel_mode`=1 is FSK; `sel_zp`=1 is zero-power. Both outputs are registered and reflect the inputs one clock later.
- R3: In tone-alert mode, `det_o` equals `tone_hit` delayed by two clocks.
- R4: In tone-alert mode, when `tone_hit` falls, `irq_n_o` goes low if the number of ticks counted while it was high lies in [QMIN_MS, QMAX_MS]. The defaults are 45 and 85, so a burst of 48 ms or 84 ms raises the interrupt.
- R5: A burst of fewer than QMIN_MS ticks, or of more than QMAX_MS ticks, leaves `irq_n_o` high. For example, 30 ms and 100 ms bursts do not raise it.
- R6: Once low in tone-alert mode, `irq_n_o` stays low until the mode changes. After the mode changes, the latch is clear, including on a later return to tone-alert.
- R7: In FSK mode, `det_o` rises only after `lvl_hit` has been 1 for ON_MS consecutive ticks (default 25). It falls only after `lvl_hit` has been 0 for OFF_MS consecutive ticks (default 8). Any reversal of `lvl_hit` restarts the count.
- R8: In FSK mode, `irq_n_o` is the inverse of `rtm_irq`.
- R9: In zero-power mode, `det_o` follows `ring_hit`. With `sel_mode`=0, `irq_n_o` is the inverse of `ring_hit`. With `sel_mode`=1, `irq_n_o` stays 1.
- R10: A change of decoded mode clears the burst timer, the level timer, the tick divider and the latch.
- R11: The tick fires once every TICK_DIV clocks, counted from reset or from the last mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_zp | input | 1 | Zero-power selection bit |
| sel_mode | input | 1 | Mode selection bit |
| tone_hit | input | 1 | Dual tone present flag |
| lvl_hit | input | 1 | FSK level above threshold flag |
| ring_hit | input | 1 | Ring or line reversal flag |
| rtm_irq | input | 1 | Data retiming interrupt request, active high |
| det_o | output | 1 | Multiplexed detect output |
| irq_n_o | output | 1 | Multiplexed interrupt, active low |

## Verification
The end of a tone burst can fall in the same cycle as a tick. A mode change can fall in the same cycle as a burst end, or in the middle of a running timer.

The bench provokes the first case by sweeping burst lengths near the window edges. It provokes the second by toggling the selection for one clock during a burst.

A behavioural model follows the ticks and latches with plain integers. Its outputs are compared with the design on every clock, so each collision is judged by the model's cycle-exact expectation.

// File: rtl/tac_pkg.sv
package tac_pkg;
  typedef enum logic [1:0] {
    MD_TONE = 2'd0,
    MD_FSK  = 2'd1,
    MD_ZPR  = 2'd2,
    MD_ZPI  = 2'd3
  } tac_mode_e;

  function automatic tac_mode_e tac_decode(input logic zp, input logic md);
    if (zp) return md ? MD_ZPI : MD_ZPR;
    return md ? MD_FSK : MD_TONE;
  endfunction
endpackage

// File: rtl/tac_tick.sv
module tac_tick #(
  parameter int TICK_DIV = 3580
) (
  input  logic clk,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick_o = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (clr_i || tick_o) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  // R11: ticks are spaced, never back to back
  a_r11_tick_spacing: assert property (@(posedge clk) disable iff (clr_i)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tac_tone_qual.sv
module tac_tone_qual #(
  parameter int QMIN_MS = 45,
  parameter int QMAX_MS = 85
) (
  input  logic clk,
  input  logic clr_i,
  input  logic tick_i,
  input  logic tone_i,
  output logic det_o,
  output logic hit_o
);
  localparam int CW = $clog2(QMAX_MS + 2);
  localparam logic [CW-1:0] SAT = CW'(QMAX_MS + 1);
  localparam logic [CW-1:0] LO  = CW'(QMIN_MS);
  localparam logic [CW-1:0] HI  = CW'(QMAX_MS);

  logic [CW-1:0] len;
  logic          fall;

  assign fall = det_o && !tone_i;

  always_ff @(posedge clk) begin
    if (clr_i) begin
      det_o <= 1'b0;
      len   <= '0;
      hit_o <= 1'b0;
    end else begin
      det_o <= tone_i;
      if (fall && len >= LO && len <= HI) hit_o <= 1'b1;
      if (!tone_i)                        len <= '0;
      else if (tick_i && len != SAT)      len <= len + 1'b1;
    end
  end

  // R6: latch holds until cleared
  a_r6_latch_hold: assert property (@(posedge clk) disable iff (clr_i)
    hit_o |=> hit_o);
  // R4: latch is set only at a burst end
  a_r4_set_at_fall: assert property (@(posedge clk) disable iff (clr_i)
    (!hit_o && !fall) |=> !hit_o);
endmodule

// File: rtl/tac_level_hyst.sv
module tac_level_hyst #(
  parameter int ON_MS  = 25,
  parameter int OFF_MS = 8
) (
  input  logic clk,
  input  logic clr_i,
  input  logic tick_i,
  input  logic lvl_i,
  output logic on_o
);
  localparam int MAXL = (ON_MS > OFF_MS) ? ON_MS : OFF_MS;
  localparam int CW   = $clog2(MAXL + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim = on_o ? CW'(OFF_MS - 1) : CW'(ON_MS - 1);

  always_ff @(posedge clk) begin
    if (clr_i) begin
      on_o <= 1'b0;
      cnt  <= '0;
    end else if (lvl_i != on_o) begin
      if (tick_i) begin
        if (cnt == lim) begin
          on_o <= ~on_o;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end else begin
      cnt <= '0;
    end
  end

  // R7: the level output moves only on a tick
  a_r7_tick_only: assert property (@(posedge clk) disable iff (clr_i)
    !tick_i |=> $stable(on_o));
endmodule

// File: rtl/tone_alert_ctrl.sv
module tone_alert_ctrl
  import tac_pkg::*;
#(
  parameter int TICK_DIV = 3580,
  parameter int QMIN_MS  = 45,
  parameter int QMAX_MS  = 85,
  parameter int ON_MS    = 25,
  parameter int OFF_MS   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_zp,
  input  logic sel_mode,
  input  logic tone_hit,
  input  logic lvl_hit,
  input  logic ring_hit,
  input  logic rtm_irq,
  output logic det_o,
  output logic irq_n_o
);
  tac_mode_e mode_now, mode_q;
  logic clr, tick, tone_det, tone_irq, lvl_on;

  assign mode_now = tac_decode(sel_zp, sel_mode);
  assign clr      = rst || (mode_now != mode_q);

  always_ff @(posedge clk) mode_q <= mode_now;

  tac_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .clr_i(clr), .tick_o(tick));

  tac_tone_qual #(.QMIN_MS(QMIN_MS), .QMAX_MS(QMAX_MS)) u_tone (
    .clk(clk), .clr_i(clr || (mode_now != MD_TONE)), .tick_i(tick),
    .tone_i(tone_hit), .det_o(tone_det), .hit_o(tone_irq));

  tac_level_hyst #(.ON_MS(ON_MS), .OFF_MS(OFF_MS)) u_lvl (
    .clk(clk), .clr_i(clr || (mode_now != MD_FSK)), .tick_i(tick),
    .lvl_i(lvl_hit), .on_o(lvl_on));

  always_ff @(posedge clk) begin
    if (rst) begin
      det_o   <= 1'b0;
      irq_n_o <= 1'b1;
    end else begin
      unique case (mode_now)
        MD_TONE: begin det_o <= tone_det; irq_n_o <= ~tone_irq; end
        MD_FSK:  begin det_o <= lvl_on;   irq_n_o <= ~rtm_irq;  end
        MD_ZPR:  begin det_o <= ring_hit; irq_n_o <= ~ring_hit; end
        default: begin det_o <= ring_hit; irq_n_o <= 1'b1;      end
      endcase
    end
  end

  // R1: outputs idle after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!det_o && irq_n_o));
  // R8: retiming interrupt passes in FSK mode
  a_r8_rtm_pass: assert property (@(posedge clk) disable iff (rst)
    (!sel_zp && sel_mode) |=> (irq_n_o == !$past(rtm_irq)));
  // R9: zero-power with mode bit set keeps interrupt idle
  a_r9_zp_quiet: assert property (@(posedge clk) disable iff (rst)
    (sel_zp && sel_mode) |=> irq_n_o);
endmodule

// File: tb/sim_tone_alert_ctrl.sv
module sim_tone_alert_ctrl;
  localparam int DIV = 4, QMIN = 45, QMAX = 85, ONT = 25, OFFT = 8;

  logic clk = 0, rst = 1;
  logic sel_zp = 0, sel_mode = 0, tone_hit = 0, lvl_hit = 0, ring_hit = 0, rtm_irq = 0;
  logic det_o, irq_n_o;
  int errs = 0, checks = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  tone_alert_ctrl #(.TICK_DIV(DIV), .QMIN_MS(QMIN), .QMAX_MS(QMAX),
                    .ON_MS(ONT), .OFF_MS(OFFT)) u0 (
    .clk(clk), .rst(rst), .sel_zp(sel_zp), .sel_mode(sel_mode),
    .tone_hit(tone_hit), .lvl_hit(lvl_hit), .ring_hit(ring_hit),
    .rtm_irq(rtm_irq), .det_o(det_o), .irq_n_o(irq_n_o));

  // behavioural reference
  int  m_mode = -1, m_tc = 0, m_len = 0, m_lc = 0;
  bit  m_tq = 0, m_lat = 0, m_on = 0, e_det = 0, e_irqn = 1;

  always @(posedge clk) begin
    int  md;
    bit  clr, tk;
    md = sel_zp ? (sel_mode ? 3 : 2) : (sel_mode ? 1 : 0);
    if (rst) begin e_det = 0; e_irqn = 1; end
    else case (md)
      0: begin e_det = m_tq; e_irqn = !m_lat; end
      1: begin e_det = m_on; e_irqn = !rtm_irq; end
      2: begin e_det = ring_hit; e_irqn = !ring_hit; end
      default: begin e_det = ring_hit; e_irqn = 1; end
    endcase
    tk  = (m_tc == DIV - 1);
    clr = rst || (md != m_mode);
    m_mode = md;
    m_tc = (clr || tk) ? 0 : m_tc + 1;
    if (clr || md != 0) begin m_tq = 0; m_len = 0; m_lat = 0; end
    else begin
      if (m_tq && !tone_hit && m_len >= QMIN && m_len <= QMAX) m_lat = 1;
      if (!tone_hit) m_len = 0;
      else if (tk && m_len < QMAX + 1) m_len++;
      m_tq = tone_hit;
    end
    if (clr || md != 1) begin m_on = 0; m_lc = 0; end
    else if (lvl_hit != m_on) begin
      if (tk) begin
        if (m_lc == (m_on ? OFFT : ONT) - 1) begin m_on = !m_on; m_lc = 0; end
        else m_lc++;
      end
    end else m_lc = 0;
  end

  task automatic chk(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    chk(cur_req, det_o, e_det, "det_o vs model");
    chk(cur_req, irq_n_o, e_irqn, "irq_n_o vs model");
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic burst(int ms);
    tone_hit = 1; cyc(ms * DIV); tone_hit = 0; cyc(4);
  endtask

  task automatic setmode(logic zp, logic md);
    sel_zp = zp; sel_mode = md; cyc(2);
  endtask

  initial begin
    cyc(4); rst = 0; cyc(1);
    chk("R1", det_o, 0, "det after reset"); chk("R1", irq_n_o, 1, "irq after reset");

    cur_req = "R3";
    tone_hit = 1; cyc(10 * DIV);
    chk("R3", det_o, 1, "tone det during burst");
    cyc(70 * DIV); tone_hit = 0; cyc(4);
    chk("R3", det_o, 0, "tone det after burst");
    chk("R4", irq_n_o, 0, "80 ms burst qualifies");
    cur_req = "R6"; cyc(50);
    chk("R6", irq_n_o, 0, "latch holds");
    setmode(0, 1);
    chk("R6", irq_n_o, 1, "cleared in FSK");
    setmode(0, 0);
    chk("R6", irq_n_o, 1, "fresh on return");

    cur_req = "R5";
    burst(30); chk("R5", irq_n_o, 1, "30 ms rejected");
    burst(100); chk("R5", irq_n_o, 1, "100 ms rejected");
    cur_req = "R4";
    burst(48); chk("R4", irq_n_o, 0, "48 ms qualifies");
    setmode(0, 1); setmode(0, 0);
    burst(84); chk("R4", irq_n_o, 0, "84 ms qualifies");
    setmode(0, 1); setmode(0, 0);

    cur_req = "R10";
    tone_hit = 1; cyc(40 * DIV);
    sel_mode = 1; cyc(1); sel_mode = 0;
    cyc(40 * DIV); tone_hit = 0; cyc(4);
    chk("R10", irq_n_o, 1, "mode blip restarts burst timer");

    cur_req = "R7"; setmode(0, 1);
    lvl_hit = 1; cyc(15 * DIV);
    chk("R7", det_o, 0, "level not yet on");
    lvl_hit = 0; cyc(2 * DIV); lvl_hit = 1; cyc(20 * DIV);
    chk("R7", det_o, 0, "reversal restarted on-delay");
    cur_req = "R11"; cyc(10 * DIV);
    chk("R11", det_o, 1, "on after 25 ticks");
    cur_req = "R7";
    lvl_hit = 0; cyc(5 * DIV);
    chk("R7", det_o, 1, "short drop ignored");
    lvl_hit = 1; cyc(DIV); lvl_hit = 0; cyc(10 * DIV);
    chk("R7", det_o, 0, "off after 8 ticks");

    cur_req = "R8";
    rtm_irq = 1; cyc(2); chk("R8", irq_n_o, 0, "rtm asserted");
    rtm_irq = 0; cyc(2); chk("R8", irq_n_o, 1, "rtm released");

    cur_req = "R9"; setmode(1, 0);
    ring_hit = 1; cyc(2);
    chk("R2", det_o, 1, "ring drives det"); chk("R9", irq_n_o, 0, "ring drives irq");
    setmode(1, 1);
    chk("R9", irq_n_o, 1, "zp mode1 irq idle"); chk("R2", det_o, 1, "zp mode1 det");
    ring_hit = 0; cyc(2); chk("R9", det_o, 0, "ring released");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(100000 * 20);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule